// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers single-cycle event pulses from neighbouring logic (a frame synchronisation hit, a buffer reaching its fill threshold, and so on) into sticky flags. A host-written enable mask picks which flags may raise one shared interrupt request. The request leaves the block as a registered, active-low line, so it does not glitch. The top mask bit is a global enable that gates every event at once.

The host reads the flag word through a read strobe. This strobe stands for the end of the command/address phase of the serial host bus. At that strobe the block latches the flag word for the host and then clears every flag and the request together. The top bit of the latched word reports whether the request was active at that moment. An event that lands in the same cycle as the clearing read is kept, so it cannot be lost. If the host enables a flag that is already pending, the request fires straight away.

Top module: `irq_status_ctl`

## Requirements
- R1: After reset all flags are 0, the mask reads 0, `irq_n_o` is 1 (inactive) and `stat_rdata_o` is 0.
- R2: A one-cycle high pulse on `evt_i[k]` sets flag k at the next clock edge. The flag stays set until a status read, and a later read returns bit k = 1.
- R3: Suppose flag k is set, mask bit k is 1 and mask bit 15 (the global enable) is 1. Then `irq_n_o` goes low at the clock edge after the flag is set, which is two edges after the event pulse.
- R4: While mask bit 15 is 0, `irq_n_o` stays high whatever the flags and the other mask bits are.
- R5: A flag whose mask bit is 0 never drives `irq_n_o` low, even when the global enable is 1.
- R6: A mask write that enables a flag which is already pending drives `irq_n_o` low at the edge after the write edge.
- R7: A cycle with `stat_rd_i` high clears all flags, and clears the request to high, at the next clock edge.
- R8: At a read-strobe edge, `stat_rdata_o` captures the flags as they were before the clear. Bits 0..14 hold flags 0..14. Bit 15 is 1 exactly when the request was active (`irq_n_o` low) in the strobe cycle. The value is held until the next strobe.
- R9: An event pulse in the same cycle as the read strobe leaves its flag set after the clear. If that flag is enabled, the request asserts again one edge after the clear.
- R10: Events that arrive in different cycles accumulate. A read returns the OR of every event seen since the last read.
- R11: `mask_rdata_o` shows the last written mask word from the edge after `mask_wr_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 15 | Event pulses, one bit per flag |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 16 | Mask word; bit 15 is the global enable |
| mask_rdata_o | output | 16 | Current mask word |
| stat_rd_i | input | 1 | Status read strobe (end of address phase) |
| stat_rdata_o | output | 16 | Status word latched at the last read strobe |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
Two things can happen in the same cycle: an event setting a flag, and the clearing read wiping all flags. The bench raises a pending, enabled flag so that the line is low, then pulses a second enabled event together with the read strobe. It checks three things: the latched word shows only the old flag with bit 15 set, the line releases at the clear edge, and the line falls again one edge later. A second read must then return only the colliding event.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

   typedef enum logic {
      EVT_PULSE = 1'b0,
      EVT_RISE  = 1'b1
   } evt_mode_e;

   function automatic logic any_enabled(input logic [31:0] flags,
                                        input logic [31:0] enables,
                                        input int unsigned count);
      logic hit;
      hit = 1'b0;
      for (int unsigned i = 0; i < 32; i++) begin
         if (i < count) hit = hit | (flags[i] & enables[i]);
      end
      return hit;
   endfunction

endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch
   import irq_ctl_pkg::*;
#(
   parameter int unsigned NUM_EVT  = 15,
   parameter evt_mode_e   EVT_MODE = EVT_PULSE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic               clr_i,
   output logic [NUM_EVT-1:0] flags_o
);

   logic [NUM_EVT-1:0] hit;

   for (genvar g = 0; g < NUM_EVT; g++) begin : g_bit
      if (EVT_MODE == EVT_RISE) begin : g_rise
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= evt_i[g];
         end
         assign hit[g] = evt_i[g] & ~prev_q;
      end else begin : g_pulse
         assign hit[g] = evt_i[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     flags_o[g] <= 1'b0;
         else if (clr_i) flags_o[g] <= hit[g];
         else            flags_o[g] <= flags_o[g] | hit[g];
      end
   end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned NUM_EVT = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] mask_o
);

   localparam int unsigned GBL_BIT = DATA_W - 1;

   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      if ((g < NUM_EVT) || (g == GBL_BIT)) begin : g_real
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    mask_o[g] <= 1'b0;
            else if (wr_i) mask_o[g] <= wdata_i[g];
         end
      end else begin : g_tied
         assign mask_o[g] = 1'b0;
      end
   end

endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen
   import irq_ctl_pkg::*;
#(
   parameter int unsigned NUM_EVT = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] flags_i,
   input  logic [NUM_EVT-1:0] enables_i,
   input  logic               gbl_en_i,
   input  logic               clr_i,
   output logic               req_o
);

   logic [31:0] flags_w;
   logic [31:0] en_w;
   logic        any_hit;

   always_comb begin
      flags_w = '0;
      en_w    = '0;
      flags_w[NUM_EVT-1:0] = flags_i;
      en_w[NUM_EVT-1:0]    = enables_i;
      any_hit = any_enabled(flags_w, en_w, NUM_EVT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     req_o <= 1'b0;
      else if (clr_i) req_o <= 1'b0;
      else            req_o <= gbl_en_i & any_hit;
   end

endmodule

// File: rtl/irq_status_ctl.sv
module irq_status_ctl
   import irq_ctl_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned NUM_EVT  = 15,
   parameter evt_mode_e   EVT_MODE = EVT_PULSE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic               mask_wr_i,
   input  logic [DATA_W-1:0]  mask_wdata_i,
   output logic [DATA_W-1:0]  mask_rdata_o,
   input  logic               stat_rd_i,
   output logic [DATA_W-1:0]  stat_rdata_o,
   output logic               irq_n_o
);

   localparam int unsigned GBL_BIT = DATA_W - 1;

   if (DATA_W < 2 || DATA_W > 32) begin : g_chk_w
      $error("irq_status_ctl: DATA_W must lie in 2..32");
   end
   if (NUM_EVT < 1 || NUM_EVT > DATA_W - 1) begin : g_chk_n
      $error("irq_status_ctl: NUM_EVT must lie in 1..DATA_W-1");
   end

   logic [NUM_EVT-1:0] flags;
   logic [DATA_W-1:0]  mask_q;
   logic               req;
   logic [DATA_W-1:0]  snap_d;
   logic [DATA_W-1:0]  snap_q;

   irq_evt_latch #(.NUM_EVT(NUM_EVT), .EVT_MODE(EVT_MODE)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (evt_i),
      .clr_i   (stat_rd_i),
      .flags_o (flags)
   );

   irq_mask_reg #(.DATA_W(DATA_W), .NUM_EVT(NUM_EVT)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (mask_wr_i),
      .wdata_i (mask_wdata_i),
      .mask_o  (mask_q)
   );

   irq_req_gen #(.NUM_EVT(NUM_EVT)) u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .flags_i   (flags),
      .enables_i (mask_q[NUM_EVT-1:0]),
      .gbl_en_i  (mask_q[GBL_BIT]),
      .clr_i     (stat_rd_i),
      .req_o     (req)
   );

   always_comb begin
      snap_d = '0;
      snap_d[NUM_EVT-1:0] = flags;
      snap_d[GBL_BIT]     = req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         snap_q <= '0;
      else if (stat_rd_i) snap_q <= snap_d;
   end

   assign stat_rdata_o = snap_q;
   assign mask_rdata_o = mask_q;
   assign irq_n_o      = ~req;

endmodule

// File: rtl/irq_status_ctl_chk.sv
module irq_status_ctl_chk #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned NUM_EVT = 15
) (
   input logic               clk,
   input logic               rst_n,
   input logic               mask_wr_i,
   input logic [DATA_W-1:0]  mask_wdata_i,
   input logic [DATA_W-1:0]  mask_rdata_o,
   input logic               stat_rd_i,
   input logic [DATA_W-1:0]  stat_rdata_o,
   input logic               irq_n_o
);

   // R7: a read strobe always leaves the line released at the next edge
   a_r7_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd_i |=> irq_n_o);

   // R4: with the global enable clear, the line stays high
   a_r4_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_rdata_o[DATA_W-1] |=> irq_n_o);

   // R8: latched bit 15 reflects the line in the strobe cycle
   a_r8_mirror_bit: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd_i |=> (stat_rdata_o[DATA_W-1] == !$past(irq_n_o)));

   // R8: latched word holds between strobes
   a_r8_snapshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_rd_i |=> $stable(stat_rdata_o));

   // R11: mask readback follows a write
   a_r11_mask_follow: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr_i |=> (mask_rdata_o[NUM_EVT-1:0] == $past(mask_wdata_i[NUM_EVT-1:0])));

   // R3: the line can only fall while globally enabled
   a_r3_fall_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n_o) |-> $past(mask_rdata_o[DATA_W-1]));

endmodule

bind irq_status_ctl irq_status_ctl_chk #(.DATA_W(DATA_W), .NUM_EVT(NUM_EVT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mask_wr_i    (mask_wr_i),
   .mask_wdata_i (mask_wdata_i),
   .mask_rdata_o (mask_rdata_o),
   .stat_rd_i    (stat_rd_i),
   .stat_rdata_o (stat_rdata_o),
   .irq_n_o      (irq_n_o)
);

// File: tb/irq_status_ctl_tb_top.sv
module irq_status_ctl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] evt_i = '0;
   logic        mask_wr_i = 1'b0;
   logic [15:0] mask_wdata_i = '0;
   logic [15:0] mask_rdata_o;
   logic        stat_rd_i = 1'b0;
   logic [15:0] stat_rdata_o;
   logic        irq_n_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_status_ctl dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt_i        (evt_i),
      .mask_wr_i    (mask_wr_i),
      .mask_wdata_i (mask_wdata_i),
      .mask_rdata_o (mask_rdata_o),
      .stat_rd_i    (stat_rd_i),
      .stat_rdata_o (stat_rdata_o),
      .irq_n_o      (irq_n_o)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr_mask(input logic [15:0] m);
      mask_wdata_i = m;
      mask_wr_i    = 1'b1;
      tick();
      mask_wr_i    = 1'b0;
   endtask

   task automatic pulse_evt(input logic [14:0] e);
      evt_i = e;
      tick();
      evt_i = '0;
   endtask

   task automatic do_read();
      stat_rd_i = 1'b1;
      tick();
      stat_rd_i = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 irq_n", {15'd0, irq_n_o}, 16'd1);
      check("R1 mask", mask_rdata_o, 16'h0000);
      check("R1 rdata", stat_rdata_o, 16'h0000);
      do_read();
      check("R1 flags clear", stat_rdata_o, 16'h0000);
   endtask

   task automatic t_single_event();
      wr_mask(16'h8004);
      check("R11 mask readback", mask_rdata_o, 16'h8004);
      pulse_evt(15'h0004);
      check("R3 not yet", {15'd0, irq_n_o}, 16'd1);
      tick();
      check("R3 irq low", {15'd0, irq_n_o}, 16'd0);
      tick();
      check("R2 sticky irq", {15'd0, irq_n_o}, 16'd0);
      do_read();
      check("R8 snapshot", stat_rdata_o, 16'h8004);
      check("R7 released", {15'd0, irq_n_o}, 16'd1);
      tick();
      check("R7 stays released", {15'd0, irq_n_o}, 16'd1);
      do_read();
      check("R7 flags cleared", stat_rdata_o, 16'h0000);
   endtask

   task automatic t_global_off();
      wr_mask(16'h7FFF);
      pulse_evt(15'h0010);
      tick(); tick();
      check("R4 gated", {15'd0, irq_n_o}, 16'd1);
      do_read();
      check("R2 flag set while gated", stat_rdata_o, 16'h0010);
   endtask

   task automatic t_bit_masked();
      wr_mask(16'h8001);
      pulse_evt(15'h0100);
      tick(); tick();
      check("R5 masked bit", {15'd0, irq_n_o}, 16'd1);
      wr_mask(16'h8101);
      check("R6 write edge", {15'd0, irq_n_o}, 16'd1);
      tick();
      check("R6 unmask pending", {15'd0, irq_n_o}, 16'd0);
      do_read();
      check("R8 snapshot unmask", stat_rdata_o, 16'h8100);
   endtask

   task automatic t_accumulate();
      wr_mask(16'h0000);
      pulse_evt(15'h0001);
      tick();
      pulse_evt(15'h4000);
      pulse_evt(15'h0020);
      do_read();
      check("R10 accumulate", stat_rdata_o, 16'h4021);
      tick(); tick();
      check("R8 hold", stat_rdata_o, 16'h4021);
   endtask

   task automatic t_collision();
      wr_mask(16'h8028);
      pulse_evt(15'h0020);
      tick();
      check("R9 pre irq", {15'd0, irq_n_o}, 16'd0);
      evt_i = 15'h0008;
      stat_rd_i = 1'b1;
      tick();
      evt_i = '0;
      stat_rd_i = 1'b0;
      check("R9 snapshot old only", stat_rdata_o, 16'h8020);
      check("R9 line released", {15'd0, irq_n_o}, 16'd1);
      tick();
      check("R9 line reasserts", {15'd0, irq_n_o}, 16'd0);
      do_read();
      check("R9 kept flag", stat_rdata_o, 16'h8008);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_single_event();
      t_global_off();
      t_bit_masked();
      t_accumulate();
      t_collision();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule